// File: doc/BRIEF.md
# Indexed Address and Branch Target Unit

This block sits beside the sequencer of an 8-bit core with a 16-bit address bus. It works out the effective address for four kinds of address step:

- absolute indexed,
- zero-page indexed,
- relative branch,
- the second byte of an indirect pointer.

It also decides how many throw-away bus reads the real core would perform before the final access. Each throw-away read is presented for exactly one cycle on a dummy-address output. The corrected final address then follows, together with a one-cycle done pulse and the number of throw-away reads spent.

A request is taken when `start` is high while the unit is idle. The inputs are captured at that edge. The sequence then plays out over one to three cycles, one cycle for each throw-away read plus one cycle for the final address. Requests that arrive while a sequence is in progress are dropped.

Mode encoding on `mode`:

| Code | Address step |
|------|--------------|
| 0 | Absolute indexed |
| 1 | Zero-page indexed |
| 2 | Relative branch |
| 3 | Pointer second byte |

Top module: `addr_step_unit`

## Requirements
- R1: After reset, `done` and `dummy_valid` are 0, and `final_addr` and `dummy_count` are 0.
- R2: In mode 0, with `force_dummy` low and no page crossing, `done` rises one cycle after the start edge with `final_addr` = `base` + `index` and `dummy_count` = 0.
- R3: In mode 0, when `base` + `index` changes the high byte, one throw-away read at {old high byte, new low byte} precedes the final address. The final address carries the corrected high byte, and `dummy_count` = 1.
- R4: In mode 0 with `force_dummy` high, the throw-away read at {old high byte, new low byte} always happens, even when no page is crossed, and `dummy_count` = 1.
- R5: In mode 1, one throw-away read at {8'h00, `base`[7:0]} is followed by `final_addr` = {8'h00, (`base`[7:0] + `index`) mod 256}. The high byte of `base` is ignored, and `dummy_count` = 1.
- R6: In mode 2 with `take` low, `done` rises one cycle after start with `final_addr` = `base` and `dummy_count` = 0.
- R7: In mode 2 with `take` high, a throw-away read at `base` comes first. The final address is `base` + the sign-extended `offset`. If the high byte is unchanged, `dummy_count` = 1.
- R8: In mode 2 with `take` high and a high-byte change, a second throw-away read at {`base` high byte, target low byte} follows the first. Then the target is given, and `dummy_count` = 2.
- R9: In mode 3, `final_addr` = {`base`[15:8], `base`[7:0] + 1}, so the low byte wraps without a carry into the high byte, and `dummy_count` = 0.
- R10: `start` is ignored while a sequence is in progress. It produces no extra outputs and does not alter the sequence underway.
- R11: `done` lasts exactly one cycle, and `done` and `dummy_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when idle |
| mode | input | 2 | Address step kind (0..3, see encoding) |
| force_dummy | input | 1 | Mode 0 only: always perform the throw-away read |
| take | input | 1 | Mode 2 only: the branch is taken |
| base | input | 16 | Base address, operand or program counter |
| index | input | 8 | Index register value |
| offset | input | 8 | Signed branch displacement |
| dummy_valid | output | 1 | A throw-away read is due this cycle |
| dummy_addr | output | 16 | Address of the throw-away read |
| done | output | 1 | One-cycle pulse with the final address |
| final_addr | output | 16 | Final effective address, held until the next request |
| dummy_count | output | 2 | Throw-away reads spent by the last request |

## Verification
Every result has a fixed due cycle, counted from the clock edge that captures `start`:

- the first throw-away read is due one cycle after that edge;
- a second one, if the request needs it, is due one cycle after the first;
- `done` falls in the cycle directly after the last throw-away read, or one cycle after the edge when none is needed.

The driver records the cycle number when it raises `start` and tags each expected item with its due cycle. The monitor samples on the falling edge and compares the item kind, the address, the count and the cycle number. Any output that turns up without a matching expected item is reported as a stray, which covers requests that should have been ignored.

// File: rtl/addr_step_unit.sv
module addr_step_unit #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              force_dummy,
  input  logic              take,
  input  logic [2*DW-1:0]   base,
  input  logic [DW-1:0]     index,
  input  logic [DW-1:0]     offset,
  output logic              dummy_valid,
  output logic [2*DW-1:0]   dummy_addr,
  output logic              done,
  output logic [2*DW-1:0]   final_addr,
  output logic [1:0]        dummy_count
);

  localparam int AW = 2 * DW;
  localparam logic [1:0] M_ABS = 2'd0;
  localparam logic [1:0] M_ZP  = 2'd1;
  localparam logic [1:0] M_BR  = 2'd2;
  localparam logic [1:0] M_PTR = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_D1, S_D2, S_FIN} st_t;

  st_t             st;
  logic [AW-1:0]   d1_q, d2_q, fin_q, base_q;
  logic [1:0]      cnt_q, mode_q;
  logic            need2_q;

  wire [AW-1:0] idx_sum = base + {{DW{1'b0}}, index};
  wire [AW-1:0] br_tgt  = base + {{DW{offset[DW-1]}}, offset};
  wire [DW-1:0] zp_lo   = base[DW-1:0] + index;
  wire [DW-1:0] ptr_lo  = base[DW-1:0] + DW'(1);

  logic          n1, n2;
  logic [AW-1:0] a1, a2, fin_n;

  always_comb begin
    n1 = 1'b0; n2 = 1'b0;
    a1 = '0; a2 = '0; fin_n = base;
    case (mode)
      M_ABS: begin
        a1    = {base[AW-1:DW], idx_sum[DW-1:0]};
        n1    = force_dummy | (idx_sum[AW-1:DW] != base[AW-1:DW]);
        fin_n = idx_sum;
      end
      M_ZP: begin
        a1    = {{DW{1'b0}}, base[DW-1:0]};
        n1    = 1'b1;
        fin_n = {{DW{1'b0}}, zp_lo};
      end
      M_BR: begin
        a1    = base;
        a2    = {base[AW-1:DW], br_tgt[DW-1:0]};
        n1    = take;
        n2    = take & (br_tgt[AW-1:DW] != base[AW-1:DW]);
        fin_n = take ? br_tgt : base;
      end
      default: fin_n = {base[AW-1:DW], ptr_lo};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      d1_q    <= '0;
      d2_q    <= '0;
      fin_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      mode_q  <= '0;
      need2_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          d1_q    <= a1;
          d2_q    <= a2;
          fin_q   <= fin_n;
          base_q  <= base;
          mode_q  <= mode;
          need2_q <= n2;
          cnt_q   <= {1'b0, n1} + {1'b0, n2};
          st      <= n1 ? S_D1 : S_FIN;
        end
        S_D1:    st <= need2_q ? S_D2 : S_FIN;
        S_D2:    st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dummy_valid = (st == S_D1) || (st == S_D2);
  assign dummy_addr  = (st == S_D2) ? d2_q : d1_q;
  assign done        = (st == S_FIN);
  assign final_addr  = fin_q;
  assign dummy_count = cnt_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && dummy_valid)); // R11
  AST_IDLE_REACTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (dummy_valid || done)); // R2
  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == M_ZP) |-> final_addr[AW-1:DW] == '0); // R5
  AST_ABS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_valid && mode_q == M_ABS) |-> dummy_addr[AW-1:DW] == base_q[AW-1:DW]); // R3
  AST_PTR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == M_PTR) |-> final_addr[AW-1:DW] == base_q[AW-1:DW]); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_valid |=> $stable(final_addr)); // R10

endmodule

// File: tb/addr_step_unit_tb.sv
module addr_step_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        force_dummy = 1'b0;
  logic        take = 1'b0;
  logic [15:0] base = 16'h0;
  logic [7:0]  index = 8'h0;
  logic [7:0]  offset = 8'h0;
  logic        dummy_valid, done;
  logic [15:0] dummy_addr, final_addr;
  logic [1:0]  dummy_count;

  addr_step_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .force_dummy(force_dummy), .take(take), .base(base), .index(index),
    .offset(offset), .dummy_valid(dummy_valid), .dummy_addr(dummy_addr),
    .done(done), .final_addr(final_addr), .dummy_count(dummy_count));

  always #4 clk = ~clk;

  typedef struct {
    bit          is_done;
    logic [15:0] addr;
    logic [1:0]  cnt;
    int          due;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && (dummy_valid || done)) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R10 stray output: dummy_valid=%0b done=%0b addr=%h expected=none",
                 dummy_valid, done, done ? final_addr : dummy_addr);
      end else begin
        item_t e;
        e = q.pop_front();
        if (e.is_done != done || cyc != e.due ||
            (done ? final_addr : dummy_addr) != e.addr ||
            (done && dummy_count != e.cnt)) begin
          bad++;
          $display("FAIL %s: done=%0b addr=%h cnt=%0d cyc=%0d expected done=%0b addr=%h cnt=%0d cyc=%0d",
                   e.req, done, done ? final_addr : dummy_addr, dummy_count, cyc,
                   e.is_done, e.addr, e.cnt, e.due);
        end
      end
    end
  end

  task automatic push_expect(input logic [1:0] m, input logic [15:0] b, input logic [7:0] ix,
                             input logic [7:0] off, input bit frc, input bit tk, input string req);
    logic [15:0] s, t, fin;
    logic [15:0] dl[$];
    s = b + {8'h00, ix};
    t = b + {{8{off[7]}}, off};
    fin = b;
    case (m)
      2'd0: begin
        if (frc || s[15:8] != b[15:8]) dl.push_back({b[15:8], s[7:0]});
        fin = s;
      end
      2'd1: begin
        dl.push_back({8'h00, b[7:0]});
        fin = {8'h00, 8'(b[7:0] + ix)};
      end
      2'd2: if (tk) begin
        dl.push_back(b);
        if (t[15:8] != b[15:8]) dl.push_back({b[15:8], t[7:0]});
        fin = t;
      end
      default: fin = {b[15:8], 8'(b[7:0] + 8'd1)};
    endcase
    for (int i = 0; i < dl.size(); i++)
      q.push_back('{1'b0, dl[i], 2'd0, cyc + 1 + i, req});
    q.push_back('{1'b1, fin, 2'(dl.size()), cyc + 1 + dl.size(), req});
  endtask

  task automatic drive(input logic [1:0] m, input logic [15:0] b, input logic [7:0] ix,
                       input logic [7:0] off, input bit frc, input bit tk);
    mode = m; base = b; index = ix; offset = off; force_dummy = frc; take = tk;
  endtask

  task automatic go(input logic [1:0] m, input logic [15:0] b, input logic [7:0] ix,
                    input logic [7:0] off, input bit frc, input bit tk, input string req);
    push_expect(m, b, ix, off, frc, tk, req);
    drive(m, b, ix, off, frc, tk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (done !== 1'b0 || dummy_valid !== 1'b0 || final_addr !== 16'h0 || dummy_count !== 2'd0) begin
      bad++;
      $display("FAIL R1: done=%b dv=%b fin=%h cnt=%0d expected 0 0 0000 0",
               done, dummy_valid, final_addr, dummy_count);
    end

    go(2'd0, 16'h1234, 8'h10, 8'h00, 1'b0, 1'b0, "R2");
    go(2'd0, 16'h12F0, 8'h20, 8'h00, 1'b0, 1'b0, "R3");
    go(2'd0, 16'hFFFF, 8'h01, 8'h00, 1'b0, 1'b0, "R3");
    go(2'd0, 16'h1234, 8'h01, 8'h00, 1'b1, 1'b0, "R4");
    go(2'd0, 16'h12F0, 8'h20, 8'h00, 1'b1, 1'b0, "R4");
    go(2'd1, 16'h00F0, 8'h20, 8'h00, 1'b0, 1'b0, "R5");
    go(2'd1, 16'hABC5, 8'h03, 8'h00, 1'b1, 1'b0, "R5");
    go(2'd2, 16'h2000, 8'h00, 8'h40, 1'b0, 1'b0, "R6");
    go(2'd2, 16'h2010, 8'h00, 8'h10, 1'b0, 1'b1, "R7");
    go(2'd2, 16'h2010, 8'h00, 8'hF0, 1'b0, 1'b1, "R7");
    go(2'd2, 16'h20F0, 8'h00, 8'h20, 1'b0, 1'b1, "R8");
    go(2'd2, 16'h2005, 8'h00, 8'h80, 1'b0, 1'b1, "R8");
    go(2'd3, 16'h30FF, 8'h00, 8'h00, 1'b0, 1'b0, "R9");
    go(2'd3, 16'h3012, 8'h00, 8'h00, 1'b0, 1'b0, "R9");

    // R10: a second start during a running sequence must be dropped
    push_expect(2'd2, 16'h20F0, 8'h00, 8'h20, 1'b0, 1'b1, "R10");
    drive(2'd2, 16'h20F0, 8'h00, 8'h20, 1'b0, 1'b1);
    start = 1'b1;
    @(negedge clk);
    drive(2'd3, 16'h5555, 8'h00, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    drive(2'd0, 16'h7777, 8'h11, 8'h00, 1'b1, 1'b0);
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    go(2'd0, 16'h0100, 8'hFF, 8'h00, 1'b0, 1'b0, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule